// File: doc/BRIEF.md
# Four-Input Fragment Merger

This block gathers the four per-input fragments that make up one event and sends them out as one larger fragment. Each of the four input receivers writes its fragment (a header word, any number of payload words, a trailer word) into one of several event slots inside the merger, choosing the slot with a slot number that travels alongside the words. A slot holds a finished fragment from an input once that input's trailer word has been written into it.

Trigger accepts arrive as slot numbers and are queued in order. The merger looks at the oldest queued slot number and waits until all four inputs have a finished fragment in that slot. It then writes an outer header, copies the four inner fragments word for word (input 1 first, input 4 last), and closes with an outer trailer. The outer trailer carries a per-input bunch-count mismatch flag and the number of inner words. The slot is then freed in every input and the queue entry is dropped. Output words are presented one per cycle and held back while the downstream FIFO reports full.

Top module: `frag_merger`

## Requirements
- R1: After reset `out_valid` is low and stays low until an accepted slot has a finished fragment from every input.
- R2: No output word appears for the slot at the head of the accept queue while any of the four inputs is still missing its trailer word for that slot; the frame starts once the last one arrives.
- R3: A frame opens with an outer header word: kind field `out_word[33:32]` = 1, bits [7:0] = the bunch count held in bits [7:0] of input 1's header, bits [15:8] = the slot number, all other data bits 0.
- R4: After the outer header, every stored word of input 1, then input 2, input 3 and input 4 appears unchanged. Each word is 34 bits with kind in [33:32] (0 payload, 1 header, 2 trailer). A fragment is the header, its payload and the trailer that ends it.
- R5: The frame closes with an outer trailer of kind 2. Data bit i (i = 0..3) is 1 exactly when bits [7:0] of input i+1's header differ from those of input 1's header. Bits [15:8] are 0.
- R6: Bits [31:16] of the outer trailer hold the number of words sent between the outer header and the outer trailer.
- R7: Frames leave in the order their slot numbers entered the accept queue. Each frame is built from the slot named by that queue entry.
- R8: A word is presented in a cycle only if `out_full` was low at the previous clock edge. Stalling delays words but never drops or repeats them.
- R9: Once its frame has been sent, a slot accepts a new fragment from every input and can be merged again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 4 | Per-input word strobe, bit i for input i+1 |
| in_slot | input | 8 | Per-input slot number, 2 bits per input |
| in_word | input | 136 | Per-input word, 34 bits per input |
| acc_valid | input | 1 | Trigger accept strobe |
| acc_slot | input | 2 | Slot number of the accepted event |
| out_full | input | 1 | Downstream FIFO full |
| out_valid | output | 1 | Output word present this cycle |
| out_word | output | 34 | Output word, kind in [33:32] |

## Verification
On every cycle the assertions check three things: output stalls against the previous cycle's full flag, a frame starts only once every input has finished the head slot, and each queue pop comes with an outer trailer on the output. They also check that a slot never overruns its depth and that the queue is never popped when empty. The exact frame contents cannot be checked that way. These are the outer header fields, the word-for-word copy in input order, the per-input mismatch bits, the word count, the frame order across slots and the reuse of a freed slot. Only the bench's scenarios show them, by comparing every captured word against frames built from the stimulus.

// File: rtl/fmrg_pkg.sv
package fmrg_pkg;

    localparam int DW   = 32;
    localparam int WW   = DW + 2;
    localparam int BC_W = 8;

    typedef enum logic [1:0] {
        K_DATA = 2'd0,
        K_HEAD = 2'd1,
        K_TAIL = 2'd2,
        K_RSVD = 2'd3
    } kind_e;

    typedef struct packed {
        kind_e          kind;
        logic [DW-1:0]  data;
    } word_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_HEAD = 2'd1,
        S_BODY = 2'd2,
        S_TAIL = 2'd3
    } mstate_e;

    function automatic word_t make_head(input logic [7:0] bc, input logic [7:0] slot);
        word_t w;
        w.kind = K_HEAD;
        w.data = {16'h0000, slot, bc};
        return w;
    endfunction

    function automatic word_t make_tail(input logic [15:0] cnt, input logic [7:0] mm);
        word_t w;
        w.kind = K_TAIL;
        w.data = {cnt, 8'h00, mm};
        return w;
    endfunction

endpackage

// File: rtl/fmrg_slot_store.sv
module fmrg_slot_store
    import fmrg_pkg::*;
#(
    parameter int N_BUF = 4,
    parameter int DEPTH = 16,
    localparam int BW   = $clog2(N_BUF),
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [BW-1:0]    wr_slot,
    input  word_t            wr_word,
    input  logic [BW-1:0]    rd_slot,
    input  logic [AW-1:0]    rd_addr,
    output word_t            rd_word,
    output logic [BC_W-1:0]  rd_bc,
    output logic [LW-1:0]    rd_len,
    output logic [N_BUF-1:0] done,
    input  logic             rel_en,
    input  logic [BW-1:0]    rel_slot
);

    word_t          mem  [N_BUF*DEPTH];
    logic [LW-1:0]  wptr [N_BUF];
    logic           wr_ok;

    assign wr_ok = wr_en && !done[wr_slot] && (wptr[wr_slot] < LW'(DEPTH));

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[int'(wr_slot)*DEPTH + int'(wptr[wr_slot][AW-1:0])] <= wr_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= '0;
            for (int b = 0; b < N_BUF; b++) wptr[b] <= '0;
        end else begin
            if (wr_ok) begin
                wptr[wr_slot] <= wptr[wr_slot] + 1'b1;
                if (wr_word.kind == K_TAIL) done[wr_slot] <= 1'b1;
            end
            if (rel_en) begin
                wptr[rel_slot] <= '0;
                done[rel_slot] <= 1'b0;
            end
        end
    end

    assign rd_word = mem[int'(rd_slot)*DEPTH + int'(rd_addr)];
    assign rd_bc   = mem[int'(rd_slot)*DEPTH].data[BC_W-1:0];
    assign rd_len  = wptr[rd_slot];

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !done[wr_slot]) |-> (wptr[wr_slot] < LW'(DEPTH)));

endmodule

// File: rtl/fmrg_accept_q.sv
module fmrg_accept_q #(
    parameter int DEPTH = 4,
    parameter int W     = 2,
    localparam int PW   = $clog2(DEPTH)
)(
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_val,
    input  logic         pop,
    output logic         empty,
    output logic [W-1:0] head
);

    logic [W-1:0] q [DEPTH];
    logic [PW:0]  rp, wp;
    logic         full;

    assign empty = (rp == wp);
    assign full  = (rp[PW-1:0] == wp[PW-1:0]) && (rp[PW] != wp[PW]);
    assign head  = q[rp[PW-1:0]];

    always_ff @(posedge clk) begin
        if (push && !full) q[wp[PW-1:0]] <= push_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rp <= '0;
            wp <= '0;
        end else begin
            if (push && !full) wp <= wp + 1'b1;
            if (pop && !empty) rp <= rp + 1'b1;
        end
    end

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/fmrg_ctrl.sv
module fmrg_ctrl
    import fmrg_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_BUF = 4,
    parameter int DEPTH = 16,
    parameter int CNT_W = 16,
    localparam int BW   = $clog2(N_BUF),
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1,
    localparam int IW   = (N_IN > 1) ? $clog2(N_IN) : 1
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_empty,
    input  logic [BW-1:0]    acc_head,
    output logic             acc_pop,
    input  logic [N_BUF-1:0] done   [N_IN],
    input  logic [LW-1:0]    len    [N_IN],
    input  logic [BC_W-1:0]  bc     [N_IN],
    input  word_t            rd_word[N_IN],
    output logic [BW-1:0]    rd_slot,
    output logic [AW-1:0]    rd_addr,
    output logic             rel_en,
    output logic [BW-1:0]    rel_slot,
    input  logic             out_full,
    output logic             out_valid,
    output word_t            out_word
);

    mstate_e          state;
    logic [BW-1:0]    cur_slot;
    logic [IW-1:0]    idx;
    logic [AW-1:0]    addr;
    logic [CNT_W-1:0] cnt;
    logic [N_IN-1:0]  mm, mm_q;
    logic [BC_W-1:0]  bc_q;
    logic             head_ready;
    logic             last_word;

    always_comb begin
        head_ready = !acc_empty;
        for (int i = 0; i < N_IN; i++) begin
            if (!done[i][acc_head]) head_ready = 1'b0;
            mm[i] = (bc[i] != bc[0]);
        end
    end

    assign rd_slot   = (state == S_IDLE) ? acc_head : cur_slot;
    assign rd_addr   = (state == S_IDLE) ? '0 : addr;
    assign last_word = ({1'b0, addr} == len[idx] - 1'b1);
    assign acc_pop   = (state == S_TAIL) && !out_full;
    assign rel_en    = acc_pop;
    assign rel_slot  = cur_slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            cur_slot  <= '0;
            idx       <= '0;
            addr      <= '0;
            cnt       <= '0;
            mm_q      <= '0;
            bc_q      <= '0;
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (head_ready) begin
                        cur_slot <= acc_head;
                        mm_q     <= mm;
                        bc_q     <= bc[0];
                        cnt      <= '0;
                        state    <= S_HEAD;
                    end
                end
                S_HEAD: begin
                    if (!out_full) begin
                        out_valid <= 1'b1;
                        out_word  <= make_head(bc_q, 8'(cur_slot));
                        idx       <= '0;
                        addr      <= '0;
                        state     <= S_BODY;
                    end
                end
                S_BODY: begin
                    if (!out_full) begin
                        out_valid <= 1'b1;
                        out_word  <= rd_word[idx];
                        cnt       <= cnt + 1'b1;
                        if (last_word) begin
                            addr <= '0;
                            if (int'(idx) == N_IN - 1) state <= S_TAIL;
                            else                       idx   <= idx + 1'b1;
                        end else begin
                            addr <= addr + 1'b1;
                        end
                    end
                end
                default: begin
                    if (!out_full) begin
                        out_valid <= 1'b1;
                        out_word  <= make_tail(16'(cnt), 8'(mm_q));
                        state     <= S_IDLE;
                    end
                end
            endcase
        end
    end

    // R8
    stall_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !$past(out_full));

    // R2
    start_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_HEAD && $past(state) == S_IDLE) |-> $past(head_ready));

    // R7
    pop_tail_chk: assert property (@(posedge clk) disable iff (rst)
        acc_pop |=> (out_valid && out_word.kind == K_TAIL));

endmodule

// File: rtl/frag_merger.sv
module frag_merger
    import fmrg_pkg::*;
#(
    parameter int N_IN   = 4,
    parameter int N_BUF  = 4,
    parameter int DEPTH  = 16,
    parameter int ACC_D  = 4,
    parameter int CNT_W  = 16,
    localparam int BW    = $clog2(N_BUF),
    localparam int AW    = $clog2(DEPTH),
    localparam int LW    = AW + 1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_IN-1:0]   in_valid,
    input  logic [N_IN*BW-1:0] in_slot,
    input  logic [N_IN*WW-1:0] in_word,
    input  logic              acc_valid,
    input  logic [BW-1:0]     acc_slot,
    input  logic              out_full,
    output logic              out_valid,
    output logic [WW-1:0]     out_word
);

    logic              acc_empty, acc_pop;
    logic [BW-1:0]     acc_head;
    logic [N_BUF-1:0]  done    [N_IN];
    logic [LW-1:0]     len     [N_IN];
    logic [BC_W-1:0]   bc      [N_IN];
    word_t             rd_word [N_IN];
    logic [BW-1:0]     rd_slot, rel_slot;
    logic [AW-1:0]     rd_addr;
    logic              rel_en;
    word_t             out_w;

    fmrg_accept_q #(.DEPTH(ACC_D), .W(BW)) u_accq (
        .clk      (clk),
        .rst      (rst),
        .push     (acc_valid),
        .push_val (acc_slot),
        .pop      (acc_pop),
        .empty    (acc_empty),
        .head     (acc_head)
    );

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        fmrg_slot_store #(.N_BUF(N_BUF), .DEPTH(DEPTH)) u_store (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (in_valid[i]),
            .wr_slot  (in_slot[i*BW +: BW]),
            .wr_word  (word_t'(in_word[i*WW +: WW])),
            .rd_slot  (rd_slot),
            .rd_addr  (rd_addr),
            .rd_word  (rd_word[i]),
            .rd_bc    (bc[i]),
            .rd_len   (len[i]),
            .done     (done[i]),
            .rel_en   (rel_en),
            .rel_slot (rel_slot)
        );
    end

    fmrg_ctrl #(.N_IN(N_IN), .N_BUF(N_BUF), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .acc_empty (acc_empty),
        .acc_head  (acc_head),
        .acc_pop   (acc_pop),
        .done      (done),
        .len       (len),
        .bc        (bc),
        .rd_word   (rd_word),
        .rd_slot   (rd_slot),
        .rd_addr   (rd_addr),
        .rel_en    (rel_en),
        .rel_slot  (rel_slot),
        .out_full  (out_full),
        .out_valid (out_valid),
        .out_word  (out_w)
    );

    assign out_word = out_w;

endmodule

// File: tb/frag_merger_tb.sv
module frag_merger_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   in_valid = '0;
    logic [7:0]   in_slot  = '0;
    logic [135:0] in_word  = '0;
    logic         acc_valid = 1'b0;
    logic [1:0]   acc_slot  = '0;
    logic         out_full  = 1'b0;
    logic         out_valid;
    logic [33:0]  out_word;

    always #4 clk = ~clk;

    frag_merger u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_slot(in_slot),
        .in_word(in_word), .acc_valid(acc_valid), .acc_slot(acc_slot),
        .out_full(out_full), .out_valid(out_valid), .out_word(out_word)
    );

    int checks = 0;
    int fails  = 0;

    logic [33:0] cap [512];
    logic [33:0] expw[512];
    string       etag[512];
    int          cap_n = 0;
    int          exp_n = 0;
    logic        stall_en = 1'b0;
    logic        full_seen = 1'b0;
    int          stall_cnt = 0;
    int          stall_viol = 0;

    // stall: {stall, slot, bc1..bc4, len1..len4}
    localparam logic [50:0] VEC [6] = '{
        {1'b0, 2'd0, 8'h11, 8'h11, 8'h11, 8'h11, 4'd3,  4'd4,  4'd2,  4'd5},
        {1'b1, 2'd1, 8'h22, 8'h23, 8'h22, 8'h22, 4'd2,  4'd2,  4'd2,  4'd2},
        {1'b0, 2'd2, 8'h40, 8'h41, 8'h42, 8'h43, 4'd6,  4'd3,  4'd7,  4'd2},
        {1'b1, 2'd3, 8'h7F, 8'h7F, 8'h7F, 8'h80, 4'd15, 4'd15, 4'd15, 4'd15},
        {1'b1, 2'd0, 8'hFF, 8'h00, 8'hFF, 8'hFF, 4'd3,  4'd3,  4'd3,  4'd3},
        {1'b0, 2'd2, 8'h05, 8'h05, 8'h06, 8'h05, 4'd2,  4'd9,  4'd4,  4'd2}
    };

    always @(negedge clk) begin
        if (out_valid) begin
            if (cap_n < 512) cap[cap_n] = out_word;
            cap_n++;
            if (full_seen) stall_viol++;
        end
        stall_cnt++;
        out_full  = stall_en && (stall_cnt % 3 != 0);
        full_seen = out_full;
    end

    function automatic logic [33:0] in_w(int i, int ev, int k, int len, logic [7:0] bc);
        if (k == 0)            return {2'd1, 8'(i), 8'(ev), 8'h00, bc};
        else if (k == len - 1) return {2'd2, 8'(i), 8'(ev), 16'hEEEE};
        else                   return {2'd0, 8'(i), 8'(ev), 16'(k)};
    endfunction

    task automatic chk(input string req, input logic [33:0] act, input logic [33:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_frag(input int i, input int s, input logic [7:0] bc, input int len, input int ev);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            in_valid[i]          = 1'b1;
            in_slot[i*2 +: 2]    = 2'(s);
            in_word[i*34 +: 34]  = in_w(i, ev, k, len, bc);
        end
        @(negedge clk);
        in_valid[i] = 1'b0;
    endtask

    task automatic push_acc(input int s);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_slot  = 2'(s);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic add_event(input int s, input logic [7:0] bcs [4], input int lens [4],
                             input int ev, input string htag);
        int tot = 0;
        logic [7:0] mm = '0;
        expw[exp_n] = {2'd1, 16'd0, 8'(s), bcs[0]};
        etag[exp_n] = htag;
        exp_n++;
        for (int i = 0; i < 4; i++) begin
            for (int k = 0; k < lens[i]; k++) begin
                expw[exp_n] = in_w(i, ev, k, lens[i], bcs[i]);
                etag[exp_n] = "R4";
                exp_n++;
                tot++;
            end
            mm[i] = (bcs[i] != bcs[0]);
        end
        expw[exp_n] = {2'd2, 16'(tot), 8'h00, mm};
        etag[exp_n] = "R5 R6";
        exp_n++;
    endtask

    task automatic clear_cap();
        @(posedge clk);
        #1;
        cap_n = 0;
        exp_n = 0;
    endtask

    task automatic check_frames(input string ordtag);
        int t = 0;
        while (cap_n < exp_n && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (6) @(negedge clk);
        checks++;
        if (cap_n != exp_n) begin
            fails++;
            $display("FAIL %s word count: actual %0d expected %0d", ordtag, cap_n, exp_n);
        end
        for (int j = 0; j < exp_n && j < cap_n; j++) chk(etag[j], cap[j], expw[j]);
    endtask

    task automatic run_vec(input int v);
        logic [50:0] e;
        logic [7:0]  bcs [4];
        int          lens [4];
        int          s;
        e = VEC[v];
        s = int'(e[49:48]);
        for (int i = 0; i < 4; i++) begin
            bcs[i]  = e[47 - 8*i -: 8];
            lens[i] = int'(e[15 - 4*i -: 4]);
        end
        clear_cap();
        stall_en   = e[50];
        stall_viol = 0;
        for (int i = 0; i < 4; i++) write_frag(i, s, bcs[i], lens[i], v);
        push_acc(s);
        add_event(s, bcs, lens, v, (v == 4) ? "R3 R9" : "R3");
        check_frames("R7");
        stall_en = 1'b0;
        checks++;
        if (stall_viol != 0) begin
            fails++;
            $display("FAIL R8 words while full: actual %0d expected 0", stall_viol);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1
        chk("R1", {33'd0, out_valid}, 34'd0);

        for (int v = 0; v < 6; v++) run_vec(v);

        // R2: three inputs present, fourth missing
        begin
            logic [7:0] bcs [4];
            int lens [4];
            bcs  = '{8'h31, 8'h31, 8'h32, 8'h31};
            lens = '{3, 2, 4, 2};
            clear_cap();
            for (int i = 0; i < 3; i++) write_frag(i, 1, bcs[i], lens[i], 10);
            push_acc(1);
            repeat (30) @(negedge clk);
            chk("R2", 34'(cap_n), 34'd0);
            write_frag(3, 1, bcs[3], lens[3], 10);
            add_event(1, bcs, lens, 10, "R2");
            check_frames("R2");
        end

        // R7: slot order follows accept order, not write order
        begin
            logic [7:0] b3 [4];
            logic [7:0] b2 [4];
            int l3 [4];
            int l2 [4];
            b3 = '{8'hA0, 8'hA0, 8'hA0, 8'hA0};
            b2 = '{8'hB0, 8'hB1, 8'hB0, 8'hB0};
            l3 = '{2, 3, 2, 2};
            l2 = '{4, 2, 2, 3};
            clear_cap();
            stall_en = 1'b1;
            stall_viol = 0;
            for (int i = 0; i < 4; i++) write_frag(i, 3, b3[i], l3[i], 20);
            for (int i = 0; i < 4; i++) write_frag(i, 2, b2[i], l2[i], 21);
            push_acc(2);
            push_acc(3);
            add_event(2, b2, l2, 21, "R7");
            add_event(3, b3, l3, 20, "R7");
            check_frames("R7");
            stall_en = 1'b0;
            checks++;
            if (stall_viol != 0) begin
                fails++;
                $display("FAIL R8 words while full: actual %0d expected 0", stall_viol);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule